// File: doc/BRIEF.md
# Iterative AES Column Mixer

This block applies the AES column-mixing transform, or its inverse, to one 32-bit state column. Only one byte-wide datapath is built. It holds a single doubling stage in GF(2^8), a few byte XORs and a selector that rotates the input lanes. The control sequencer reuses that datapath for each of the four output bytes. In forward mode each output byte takes one cycle. In inverse mode each output byte takes three cycles, because the inverse coefficients are built by Horner evaluation: the doubling stage is applied three times to a running accumulator.

A column is offered on the input stream with `in_valid`. It is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time a column is in flight. Any `in_valid` seen in that time is simply not taken, and the offered data stay at the source until `in_ready` returns. The output side has no back-pressure. `out_valid` is a single-cycle pulse that marks a new result on `out_col`. That result then stays unchanged until the next column completes.

Top module: `mixcol_iter`

## Requirements
- R1: With `in_inv` low at acceptance, the result is the forward mix. Lane 0 is bits 31:24 and lane 3 is bits 7:0. Output lane i = 2·a[i] ⊕ 3·a[i+1] ⊕ a[i+2] ⊕ a[i+3], with indices taken mod 4, multiplication in GF(2^8) and reduction constant 0x1B. Example: 32'hdb135345 gives 32'h8e4da1bc.
- R2: With `in_inv` high at acceptance, the result is the inverse mix, with coefficients 0E, 0B, 0D and 09 on a[i], a[i+1], a[i+2] and a[i+3]. It undoes R1. Example: 32'h8e4da1bc gives 32'hdb135345.
- R3: `in_ready` is high when the block is idle. A column is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the edge after acceptance until the result is delivered.
- R4: An `in_valid` that arrives while a column is in flight is not accepted. It changes neither the result of the column in flight nor its timing.
- R5: `out_valid` rises 4 clock edges after the acceptance edge in forward mode and 12 edges after it in inverse mode.
- R6: `out_valid` is high for exactly one cycle per accepted column. `out_col` changes only on the edge where `out_valid` rises, and it holds its value otherwise.
- R7: The mode is sampled only on the acceptance edge. Changing `in_inv` while a column is in flight has no effect on that column.
- R8: While `rst_n` is low, `in_ready` = 1, `out_valid` = 0 and `out_col` = 0.
- R9: `in_ready` is high in the cycle where `out_valid` is high, so a new column can be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input column offered |
| in_ready | output | 1 | Block idle and able to accept a column |
| in_col | input | 32 | Input column, lane 0 in bits 31:24 |
| in_inv | input | 1 | 1 selects the inverse transform, sampled at acceptance |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_col | output | 32 | Result column, same lane order as the input |

## Verification
Some properties are checked on every cycle by the assertions:
- `in_ready` drops after every acceptance and comes back only together with a result pulse.
- The result pulse lasts a single cycle, and `out_col` does not move outside it.
- The number of cycles from acceptance to result matches the mode that was latched at acceptance.

The byte values themselves can only be shown by the bench scenarios. These include the known forward and inverse columns, uniform columns, round trips on random columns through both modes, and overlapping offers during a busy period with the mode flipped. A behavioural model that follows every clock shows that those offers neither alter the result in flight nor its mode, and that a held offer is taken at the first idle edge.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W    = 8;
  localparam int LANES     = 4;
  localparam int COL_W     = BYTE_W * LANES;
  localparam int LANE_W    = $clog2(LANES);
  localparam int FWD_STEPS = 1;
  localparam int INV_STEPS = 3;
  localparam int STEP_W    = $clog2(INV_STEPS);
  localparam int LAT_FWD   = LANES * FWD_STEPS;
  localparam int LAT_INV   = LANES * INV_STEPS;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef enum logic {MODE_FWD = 1'b0, MODE_INV = 1'b1} mode_e;

  // multiply by x in GF(2^8): shift left, fold the carry back with the reduction constant
  function automatic byte_t gf_double(byte_t a, byte_t poly);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? poly : '0);
  endfunction
endpackage

// File: rtl/mixcol_byte_unit.sv
module mixcol_byte_unit
  import mixcol_pkg::*;
#(
  parameter byte_t POLY = 8'h1B
) (
  input  logic [COL_W-1:0] col_i,
  input  lane_t            lane_i,
  input  step_t            step_i,
  input  mode_e            mode_i,
  input  byte_t            acc_i,
  output byte_t            byte_o
);
  byte_t lane_a [LANES];
  byte_t rot    [LANES];
  byte_t dbl_in;
  byte_t addend;
  byte_t tail;

  // lane j of the column sits at the MSB end shifted down by j bytes
  for (genvar j = 0; j < LANES; j++) begin : g_split
    assign lane_a[j] = col_i[COL_W-1-j*BYTE_W -: BYTE_W];
  end

  // selector: rot[k] is lane (lane_i + k) mod LANES
  for (genvar k = 0; k < LANES; k++) begin : g_rot
    assign rot[k] = lane_a[lane_t'(lane_i + lane_t'(k))];
  end

  assign tail = rot[1] ^ rot[2] ^ rot[3];

  always_comb begin
    if (mode_i == MODE_FWD) begin
      dbl_in = rot[0] ^ rot[1];
      addend = tail;
    end else begin
      // Horner form: x(x(x(S) + a0+a2) + a0+a1) + a1+a2+a3
      case (step_i)
        step_t'(0): begin
          dbl_in = rot[0] ^ rot[1] ^ rot[2] ^ rot[3];
          addend = rot[0] ^ rot[2];
        end
        step_t'(1): begin
          dbl_in = acc_i;
          addend = rot[0] ^ rot[1];
        end
        default: begin
          dbl_in = acc_i;
          addend = tail;
        end
      endcase
    end
  end

  assign byte_o = gf_double(dbl_in, POLY) ^ addend;
endmodule

// File: rtl/mixcol_ctrl.sv
module mixcol_ctrl
  import mixcol_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept_i,
  input  mode_e mode_i,
  output logic  busy_o,
  output lane_t lane_o,
  output step_t step_o,
  output mode_e mode_o,
  output logic  byte_last_o,
  output logic  col_last_o,
  output logic  done_o
);
  logic  busy_q;
  lane_t lane_q;
  step_t step_q;
  mode_e mode_q;
  logic  done_q;
  step_t last_step;

  always_comb begin
    last_step = (mode_q == MODE_INV) ? step_t'(INV_STEPS-1) : step_t'(FWD_STEPS-1);
  end

  assign byte_last_o = busy_q && (step_q == last_step);
  assign col_last_o  = byte_last_o && (lane_q == lane_t'(LANES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lane_q <= '0;
      step_q <= '0;
      mode_q <= MODE_FWD;
      done_q <= 1'b0;
    end else begin
      done_q <= col_last_o;
      if (accept_i) begin
        busy_q <= 1'b1;
        lane_q <= '0;
        step_q <= '0;
        mode_q <= mode_i;
      end else if (busy_q) begin
        if (byte_last_o) begin
          step_q <= '0;
          if (col_last_o) busy_q <= 1'b0;
          else            lane_q <= lane_q + lane_t'(1);
        end else begin
          step_q <= step_q + step_t'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign lane_o = lane_q;
  assign step_o = step_q;
  assign mode_o = mode_q;
  assign done_o = done_q;
endmodule

// File: rtl/mixcol_iter.sv
module mixcol_iter
  import mixcol_pkg::*;
#(
  parameter byte_t POLY = 8'h1B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [COL_W-1:0] in_col,
  input  logic             in_inv,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);
  logic             accept;
  logic             busy;
  lane_t            lane;
  step_t            step;
  mode_e            mode;
  logic             byte_last;
  logic             col_last;
  logic             done;
  byte_t            unit_byte;
  byte_t            acc_q;
  logic [COL_W-1:0] src_q;
  logic [COL_W-1:0] work_q;
  logic [COL_W-1:0] out_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  mixcol_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .mode_i      (mode_e'(in_inv)),
    .busy_o      (busy),
    .lane_o      (lane),
    .step_o      (step),
    .mode_o      (mode),
    .byte_last_o (byte_last),
    .col_last_o  (col_last),
    .done_o      (done)
  );

  mixcol_byte_unit #(.POLY(POLY)) u_unit (
    .col_i  (src_q),
    .lane_i (lane),
    .step_i (step),
    .mode_i (mode),
    .acc_i  (acc_q),
    .byte_o (unit_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      acc_q  <= '0;
      work_q <= '0;
      out_q  <= '0;
    end else begin
      if (accept) src_q <= in_col;
      if (busy) begin
        acc_q <= unit_byte;
        if (byte_last) work_q[COL_W-1-int'(lane)*BYTE_W -: BYTE_W] <= unit_byte;
        // last lane is the low byte; publish the whole column at once
        if (col_last) out_q <= {work_q[COL_W-1:BYTE_W], unit_byte};
      end
    end
  end

  assign out_valid = done;
  assign out_col   = out_q;
endmodule

// File: rtl/mixcol_chk.sv
module mixcol_chk
  import mixcol_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_inv,
  input logic             out_valid,
  input logic [COL_W-1:0] out_col
);
  localparam int CNT_W = $clog2(LAT_INV + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inv_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      cnt_q <= '0;
      inv_q <= in_inv;
    end else if (!in_ready && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_col));

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q == (inv_q ? CNT_W'(LAT_INV) : CNT_W'(LAT_FWD))));

  a_r9_ready_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

bind mixcol_iter mixcol_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_inv    (in_inv),
  .out_valid (out_valid),
  .out_col   (out_col)
);

// File: tb/tb_mixcol_iter.sv
`timescale 1ns/1ps
module tb_mixcol_iter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_col = '0;
  logic        in_inv = 1'b0;
  logic        out_valid;
  logic [31:0] out_col;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mixcol_iter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_col(in_col), .in_inv(in_inv), .out_valid(out_valid), .out_col(out_col)
  );

  function automatic logic [7:0] gmul(input logic [7:0] c, input logic [7:0] a);
    logic [15:0] p = '0;
    for (int b = 0; b < 8; b++) if (c[b]) p = p ^ (16'(a) << b);
    for (int b = 15; b >= 8; b--) if (p[b]) p = p ^ (16'h011B << (b - 8));
    return p[7:0];
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] col, input logic inv);
    logic [7:0] a [4];
    logic [7:0] c [4];
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) a[j] = col[31-8*j -: 8];
    if (inv) begin c[0] = 8'h0e; c[1] = 8'h0b; c[2] = 8'h0d; c[3] = 8'h09; end
    else     begin c[0] = 8'h02; c[1] = 8'h03; c[2] = 8'h01; c[3] = 8'h01; end
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v = '0;
      for (int t = 0; t < 4; t++) v = v ^ gmul(c[t], a[(i+t)%4]);
      r[31-8*i -: 8] = v;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle reference model
  int          m_left = 0;
  logic        m_valid = 0;
  logic        m_inv = 0;
  logic [31:0] m_pend = '0;
  logic [31:0] m_out = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_left = 0; m_valid = 0; m_out = '0;
    end else begin
      m_valid = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_valid = 1; m_out = m_pend; end
      end else if (in_valid) begin
        m_pend = mix(in_col, in_inv);
        m_inv  = in_inv;
        m_left = in_inv ? 12 : 4;
      end
    end
    if (cyc > 20000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 in_ready vs model", {31'b0, in_ready}, {31'b0, m_left == 0});
      chk("R6 out_valid vs model", {31'b0, out_valid}, {31'b0, m_valid});
      chk(m_inv ? "R2 out_col vs model" : "R1 out_col vs model", out_col, m_out);
    end
  end

  task automatic run(input logic [31:0] col, input logic inv,
                     output logic [31:0] res, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_col = col; in_inv = inv;
    @(negedge clk);
    in_valid = 0;
    lat = 0;
    while (!out_valid) begin @(negedge clk); lat++; end
    res = out_col;
  endtask

  logic [31:0] res, res2, rnd;
  int lat, gap;

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 in_ready in reset", {31'b0, in_ready}, 32'd1);
    chk("R8 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R8 out_col in reset", out_col, 32'h0);
    rst_n = 1;

    run(32'hdb135345, 0, res, lat);
    chk("R1 known column", res, 32'h8e4da1bc);
    chk("R5 forward latency", lat, 4);
    run(32'h8e4da1bc, 1, res, lat);
    chk("R2 known column", res, 32'hdb135345);
    chk("R5 inverse latency", lat, 12);
    run(32'hf20a225c, 0, res, lat);
    chk("R1 column f20a225c", res, 32'h9fdc589d);
    run(32'h2d26314c, 0, res, lat);
    chk("R1 column 2d26314c", res, 32'h4d7ebdf8);
    run(32'hd4d4d4d5, 0, res, lat);
    chk("R1 column d4d4d4d5", res, 32'hd5d5d7d6);
    run(32'hd5d5d7d6, 1, res, lat);
    chk("R2 column d5d5d7d6", res, 32'hd4d4d4d5);
    run(32'hc6c6c6c6, 0, res, lat);
    chk("R1 uniform column", res, 32'hc6c6c6c6);
    run(32'hc6c6c6c6, 1, res, lat);
    chk("R2 uniform column", res, 32'hc6c6c6c6);
    repeat (3) @(negedge clk);
    chk("R6 result held while idle", out_col, 32'hc6c6c6c6);

    // offers during busy with flipped mode, then held offer taken at first idle edge
    @(negedge clk);
    in_valid = 1; in_col = 32'hdb135345; in_inv = 0;
    @(negedge clk);
    in_col = 32'h9fdc589d; in_inv = 1;
    lat = 0;
    while (!out_valid) begin @(negedge clk); lat++; end
    chk("R4 busy offer ignored", out_col, 32'h8e4da1bc);
    chk("R7 mode change ignored latency", lat, 4);
    chk("R9 ready at result", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 0;
    gap = 1;
    while (!out_valid) begin @(negedge clk); gap++; end
    chk("R9 back-to-back result", out_col, 32'hf20a225c);
    chk("R9 back-to-back gap", gap, 13);

    for (int n = 0; n < 20; n++) begin
      rnd = $urandom;
      run(rnd, 0, res, lat);
      chk("R1 random forward", res, mix(rnd, 0));
      run(res, 1, res2, lat);
      chk("R2 random round trip", res2, rnd);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule